// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus. Software sets up a 32-bit command word holding the frame type, opcode, PHY address and register or device address. Setting the start bit in that word launches one frame on MDC/MDIO. The block divides the system clock to make MDC. It shifts out a 64-bit frame with MDIO output changes placed on MDC falling edges. It releases the data line for the reply of a read and samples the reply on MDC rising edges.

The same engine issues three kinds of frame:
- Clause 22 register frames.
- Clause 45 address frames, whose 16 data bits come from a separate address register.
- Clause 45 write, read and read-increment frames.

Software polls the start bit, which reads back as 1 for the whole frame. A read whose second turnaround bit is not pulled low by the PHY sets a sticky failure flag. The next started command clears that flag.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0, MDC is low and the MDIO output enable is low.
- R2: Register byte offsets are 0x00 command, 0x04 Clause 45 address, 0x08 write data, 0x0C read data and 0x10 status. The address and write-data registers keep bits 15:0 of a write and read back with zero upper bits.
- R3: The command word has the device/register field in bits 4:0, the PHY address in bits 9:5, the opcode in bits 11:10, the frame-type field in bits 13:12 and start in bit 14. A command write while idle stores bits 13:0. If bit 14 is set, the write starts a frame and bit 14 reads 1 from the next cycle for exactly 128*HALF_DIV cycles. If bit 14 is clear, no frame starts.
- R4: While a frame is in progress, writes to the command register are ignored: its fields do not change and the running frame is not disturbed.
- R5: MDC is low when idle. During a frame it starts low and toggles every HALF_DIV system cycles, giving 64 MDC periods.
- R6: The frame goes out MSB first: 32 ones, the 2-bit frame-type field (00 selects Clause 45, 01 selects Clause 22), the 2-bit opcode, 5-bit PHY address, 5-bit device/register field, 2 turnaround bits, then 16 data bits. MDIO output changes only on MDC falling edges.
- R7: For a frame with opcode bit 11 clear, the turnaround is driven as 1 then 0. The data bits are the address register's bits 15:0 when the frame type is 00 and the opcode is 00; otherwise they are the write-data register's bits 15:0.
- R8: A frame with opcode bit 11 set is a read. MDIO is released from the first turnaround bit to the end of the frame. The 16 data bits are sampled on MDC rising edges and appear in read-data bits 15:0 when the frame ends. A write frame leaves read-data unchanged.
- R9: Status bit 0 is set when MDIO is high at the MDC rising edge of the second turnaround bit of a read. It is cleared one cycle after the next command starts.
- R10: The Clause 45 read-increment opcode (10) behaves as a read on the wire, as does opcode 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The start bit is due one cycle after the edge that accepts the command, and it clears exactly 128*HALF_DIV cycles later. On that same edge the captured read data appears. The failure flag is set at the rising MDC edge of the second turnaround bit and cleared one cycle after the next start. The bench keeps a behavioural model that counts edges since the start. On every falling system-clock edge it compares MDC, the output enable and the driven MDIO bit against that count. It also drives the PHY reply from the same count, so every register read lands on a cycle whose expected value is already settled.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [4:0] OFF_CMD   = 5'h00;
  localparam logic [4:0] OFF_ADDR  = 5'h04;
  localparam logic [4:0] OFF_WDATA = 5'h08;
  localparam logic [4:0] OFF_RDATA = 5'h0C;
  localparam logic [4:0] OFF_STAT  = 5'h10;

  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_FIRST   = 46;
  localparam int unsigned TA_SECOND  = 47;
  localparam int unsigned DATA_FIRST = 48;
  localparam int unsigned START_BIT  = 14;

  localparam logic [1:0] FT_C45 = 2'b00;
  localparam logic [1:0] OP_ADR = 2'b00;

  typedef struct packed {
    logic [1:0] ftype;
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] dev;
  } mdio_cmd_t;

  function automatic logic is_read(input mdio_cmd_t c);
    return c.op[1];
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned HALF_DIV = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == LAST);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [4:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic            busy_i,
  input  logic            cap_valid_i,
  input  logic [15:0]     cap_data_i,
  input  logic            fail_set_i,
  output mdio_cmd_t       cmd_o,
  output logic [15:0]     addr_reg_o,
  output logic [15:0]     wdata_reg_o,
  output logic            start_o,
  output logic            fail_o
);
  mdio_cmd_t   cmd_q;
  logic [15:0] addr_q, wdat_q, rdat_q;
  logic        fail_q;
  logic        cmd_wr;
  logic        unused_bits;

  assign unused_bits = ^wdata_i[31:15];
  assign cmd_wr  = we_i && (addr_i == OFF_CMD) && !busy_i;
  assign start_o = cmd_wr && wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      fail_q <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= mdio_cmd_t'(wdata_i[13:0]);
      if (we_i && addr_i == OFF_ADDR)  addr_q <= wdata_i[15:0];
      if (we_i && addr_i == OFF_WDATA) wdat_q <= wdata_i[15:0];
      if (cap_valid_i) rdat_q <= cap_data_i;
      if (start_o)         fail_q <= 1'b0;
      else if (fail_set_i) fail_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_CMD:   rdata_o = {17'b0, busy_i, cmd_q};
      OFF_ADDR:  rdata_o = {16'b0, addr_q};
      OFF_WDATA: rdata_o = {16'b0, wdat_q};
      OFF_RDATA: rdata_o = {16'b0, rdat_q};
      OFF_STAT:  rdata_o = {31'b0, fail_q};
      default:   rdata_o = '0;
    endcase
  end

  assign cmd_o       = cmd_q;
  assign addr_reg_o  = addr_q;
  assign wdata_reg_o = wdat_q;
  assign fail_o      = fail_q;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  mdio_cmd_t   cmd_i,
  input  logic [15:0] addr_reg_i,
  input  logic [15:0] wdata_reg_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        cap_valid_o,
  output logic [15:0] cap_data_o,
  output logic        fail_set_o
);
  localparam int unsigned IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);

  logic                  busy_q, rd_q;
  logic [IW-1:0]         idx_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [15:0]           shr_q;
  logic                  rd_n;
  logic [1:0]            ta_n;
  logic [15:0]           dat_n;

  // start strobe only reaches here while idle, so cmd_i is the new command next cycle;
  // the frame is built from the value being written via regs one edge later
  always_comb begin
    rd_n  = is_read(cmd_i);
    ta_n  = rd_n ? 2'b11 : 2'b10;
    if (rd_n)
      dat_n = 16'hFFFF;
    else if (cmd_i.ftype == FT_C45 && cmd_i.op == OP_ADR)
      dat_n = addr_reg_i;
    else
      dat_n = wdata_reg_i;
  end

  logic load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      load_q  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      frame_q <= '1;
      shr_q   <= '0;
    end else begin
      load_q <= start_i;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (fall_i) begin
          if (idx_q == IDX_LAST) busy_q <= 1'b0;
          else                   idx_q  <= idx_q + 1'b1;
        end
        if (rise_i && rd_q && idx_q >= IW'(DATA_FIRST))
          shr_q <= {shr_q[14:0], mdio_i};
      end
      if (load_q) begin
        rd_q    <= rd_n;
        frame_q <= {32'hFFFF_FFFF, cmd_i.ftype, cmd_i.op, cmd_i.phy, cmd_i.dev, ta_n, dat_n};
      end
    end
  end

  assign busy_o      = busy_q;
  assign mdio_o      = busy_q ? frame_q[IDX_LAST - idx_q] : 1'b1;
  assign mdio_oe_o   = busy_q && !(rd_q && idx_q >= IW'(TA_FIRST));
  assign cap_valid_o = busy_q && fall_i && rd_q && (idx_q == IDX_LAST);
  assign cap_data_o  = shr_q;
  assign fail_set_o  = busy_q && rise_i && rd_q && (idx_q == IW'(TA_SECOND)) && mdio_i;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  mdio_cmd_t   cmd;
  logic [15:0] addr_reg, wdata_reg, cap_data;
  logic        busy, start, fail, fail_set, cap_valid, rise, fall;

  mdio_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (busy),
    .cap_valid_i (cap_valid),
    .cap_data_i  (cap_data),
    .fail_set_i  (fail_set),
    .cmd_o       (cmd),
    .addr_reg_o  (addr_reg),
    .wdata_reg_o (wdata_reg),
    .start_o     (start),
    .fail_o      (fail)
  );

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmd_i       (cmd),
    .addr_reg_i  (addr_reg),
    .wdata_reg_i (wdata_reg),
    .rise_i      (rise),
    .fall_i      (fall),
    .mdio_i      (mdio_i),
    .busy_o      (busy),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o),
    .cap_valid_o (cap_valid),
    .cap_data_o  (cap_data),
    .fail_set_o  (fail_set)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic start_i,
  input logic fail_i,
  input logic mdc_i,
  input logic mdio_i,
  input logic oe_i
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i); // R5
  AST_OE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i); // R1
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i); // R3
  AST_FAIL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !fail_i); // R9
  AST_FAIL_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_i) |-> $rose(mdc_i)); // R9
  AST_MDIO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$stable(mdio_i)) |-> $fell(mdc_i)); // R6
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy),
  .start_i (start),
  .fail_i  (fail),
  .mdc_i   (mdc_o),
  .mdio_i  (mdio_o),
  .oe_i    (mdio_oe_o)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/100ps
module mdio_master_test;
  localparam int HALF = 4;
  localparam int TX   = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;
  logic        phy_drv = 1'b1;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  assign mdio_in = mdio_oe ? mdio_out : phy_drv;

  mdio_master #(.HALF_DIV(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // behavioural reference
  bit          mbusy = 0;
  int          n = 0;
  logic [63:0] mframe = '1;
  bit          mrd = 0;
  logic [15:0] maddr = 0, mwdata = 0;
  logic [15:0] phy_data = 16'h0000;
  bit          phy_ta = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit was_busy;
      was_busy = mbusy;
      if (was_busy) begin
        n++;
        if (n == TX) mbusy = 0;
      end else if (we && addr == 5'h00 && wdata[14]) begin
        logic [1:0] ft, op;
        ft = wdata[13:12];
        op = wdata[11:10];
        mrd = op[1];
        mframe = {32'hFFFF_FFFF, wdata[13:0], mrd ? 2'b11 : 2'b10,
                  mrd ? 16'hFFFF : ((ft == 2'b00 && op == 2'b00) ? maddr : mwdata)};
        mbusy = 1;
        n = 0;
      end
      if (we && addr == 5'h04) maddr = wdata[15:0];
      if (we && addr == 5'h08) mwdata = wdata[15:0];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int b;
      bit emdc, eoe;
      b = n / (2 * HALF);
      emdc = mbusy && ((n / HALF) % 2 == 1);
      eoe  = mbusy && !(mrd && b >= 46);
      checks++;
      if (mdc !== emdc) begin
        errors++; $display("FAIL R5 mdc at n=%0d got %b exp %b", n, mdc, emdc);
      end else if (mdio_oe !== eoe) begin
        errors++; $display("FAIL R8 oe at n=%0d got %b exp %b", n, mdio_oe, eoe);
      end else if (eoe && mdio_out !== mframe[63-b]) begin
        errors++; $display("FAIL R6 mdio bit %0d got %b exp %b", b, mdio_out, mframe[63-b]);
      end
      if (mbusy && mrd && b == 47)      phy_drv = phy_ta;
      else if (mbusy && mrd && b >= 48) phy_drv = phy_data[63-b];
      else                              phy_drv = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++; $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] mk(input logic go, input logic [1:0] ft,
                                     input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] dev);
    return {17'b0, go, ft, op, phy, dev};
  endfunction

  task automatic wait_idle(output int cyc);
    logic [31:0] d;
    cyc = 0;
    forever begin
      rd(5'h00, d);
      if (!d[14]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(5'h00, d); chk("R1 cmd", d, 0);
    rd(5'h04, d); chk("R1 addr", d, 0);
    rd(5'h08, d); chk("R1 wdata", d, 0);
    rd(5'h0C, d); chk("R1 rdata", d, 0);
    rd(5'h10, d); chk("R1 status", d, 0);
    chk("R1 mdc/oe", {30'b0, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register widths
    wr(5'h04, 32'hFFFF_1234); rd(5'h04, d); chk("R2 addr", d, 32'h1234);
    wr(5'h08, 32'hDEAD_BEEF); rd(5'h08, d); chk("R2 wdata", d, 32'hBEEF);

    // R3 command without start
    wr(5'h00, mk(0, 2'b01, 2'b01, 5'h03, 5'h11));
    rd(5'h00, d); chk("R3 no-start fields", d, mk(0, 2'b01, 2'b01, 5'h03, 5'h11));
    repeat (2 * HALF) @(negedge clk);
    chk("R3 no-start mdc", {31'b0, mdc}, 0);

    // R3 R7 clause 22 write, busy length
    wr(5'h00, mk(1, 2'b01, 2'b01, 5'h03, 5'h11));
    rd(5'h00, d); chk("R3 busy readback", d, mk(1, 2'b01, 2'b01, 5'h03, 5'h11));
    wait_idle(cyc); chk("R3 busy cycles", cyc, TX);

    // R4 R8 clause 22 read with ignored command write
    phy_data = 16'hA5C3; phy_ta = 0;
    wr(5'h00, mk(1, 2'b01, 2'b10, 5'h07, 5'h09));
    repeat (20) @(negedge clk);
    wr(5'h00, mk(1, 2'b00, 2'b00, 5'h01, 5'h01));
    rd(5'h00, d); chk("R4 cmd held", d, mk(1, 2'b01, 2'b10, 5'h07, 5'h09));
    wait_idle(cyc); chk("R4 frame length kept", cyc, TX - 22);
    rd(5'h0C, d); chk("R8 c22 rdata", d, 32'hA5C3);
    rd(5'h10, d); chk("R9 status ok", d, 0);

    // R7 clause 45 address then write
    wr(5'h00, mk(1, 2'b00, 2'b00, 5'h02, 5'h01)); wait_idle(cyc);
    wr(5'h00, mk(1, 2'b00, 2'b01, 5'h02, 5'h01)); wait_idle(cyc);
    rd(5'h0C, d); chk("R8 write keeps rdata", d, 32'hA5C3);

    // R8 R10 clause 45 read and read-increment
    phy_data = 16'h0F0F;
    wr(5'h00, mk(1, 2'b00, 2'b11, 5'h02, 5'h01)); wait_idle(cyc);
    rd(5'h0C, d); chk("R8 c45 read", d, 32'h0F0F);
    phy_data = 16'h8001;
    wr(5'h00, mk(1, 2'b00, 2'b10, 5'h02, 5'h01)); wait_idle(cyc);
    rd(5'h0C, d); chk("R10 read-inc", d, 32'h8001);

    // R9 failed turnaround, cleared by next start
    phy_ta = 1;
    wr(5'h00, mk(1, 2'b01, 2'b10, 5'h04, 5'h02)); wait_idle(cyc);
    rd(5'h10, d); chk("R9 fail set", d, 1);
    phy_ta = 0;
    wr(5'h00, mk(1, 2'b01, 2'b01, 5'h04, 5'h02));
    rd(5'h10, d); chk("R9 fail cleared", d, 0);
    wait_idle(cyc);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule